// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a compact 32-bit processor that completes one instruction in every clock cycle. In that cycle it fetches a word from a private instruction store, decodes it, reads up to two registers, computes with a small arithmetic unit, optionally touches a private data store, and commits at most one register result together with the next program counter. It runs ten operations: register add, subtract, and, or and signed set-less-than; add-immediate; word load and word store; branch-if-equal; and absolute jump.

Both stores are small word arrays indexed by address bits [7:2]. Before a run, the surrounding logic fills them through two plain load strobes that share one address and one data bus, while reset is held. After reset is released the core runs freely. The program counter is always visible on an output. Any register can be read combinationally through a select input, which lets a checker follow the architectural state.

There are no streaming interfaces. Every pin is a plain control or status signal, so there is no back-pressure and no handshake. A load strobe is accepted in the cycle it is high.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0.
- R2: After any instruction that is not a taken branch or a jump, the program counter rises by 4. It always stays a multiple of 4.
- R3: Register 0 always reads as zero. An instruction that targets register 0 leaves it at zero.
- R4: Opcode 0x00 selects a register operation on fields rs[25:21], rt[20:16] and rd[15:11]. The funct field [5:0] chooses the operation: 0x20 add, 0x22 subtract (rs−rt), 0x24 and, 0x25 or, 0x2A signed set-less-than (1 if rs<rt, else 0). The result is written to rd. Operands are the register values from before the cycle's write, so rd may equal rs or rt.
- R5: Opcode 0x08 writes rs plus the sign-extended immediate [15:0] into rt.
- R6: Opcode 0x23 loads and opcode 0x2B stores. Both use the address rs plus the sign-extended immediate. A load writes the addressed word into rt. A store writes rt into the addressed word and changes no register. The word index is address bits [7:2].
- R7: Opcode 0x04 compares rs and rt. If they are equal, the next PC is PC+4+(sign-extended immediate×4). Otherwise it is PC+4.
- R8: Opcode 0x02 sets the next PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R9: An opcode, or an opcode-0 funct value, not listed above writes no register and no memory, and the PC rises by 4.
- R10: `ld_imem_en` or `ld_dmem_en` writes `ld_data` into the word at `ld_addr[7:2]` of the instruction or data store, whatever the state of `rst`. The core's own stores are suppressed while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_imem_en | input | 1 | Write strobe into the instruction store |
| ld_dmem_en | input | 1 | Write strobe into the data store |
| ld_addr | input | 32 | Byte address for a load strobe |
| ld_data | input | 32 | Word written by a load strobe |
| peek_sel | input | 5 | Register selected for observation |
| peek_data | output | 32 | Current value of the selected register |
| pc_out | output | 32 | Current program counter |

## Verification
Within one instruction, the register file is read and written at the same moment. The sharpest case is an add whose destination is also both of its sources: doubling a register must use the old value and commit the new one at the edge. The bench provokes this by doubling a register that holds 4 and expecting 8, not 16. The same collision appears when a load writes to a register while its address comes from another register just set up. A store followed immediately by a load of the same word shows whether memory write and read ordering is consistent across adjacent cycles. The per-cycle program-counter trace confirms that no cycle is lost or repeated around the branches and the jump.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_REG  = 6'h00;
  localparam logic [5:0] OP_JMP  = 6'h02;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LDW  = 6'h23;
  localparam logic [5:0] OP_STW  = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    use_imm;
    logic    mem_re;
    logic    mem_we;
    logic    is_beq;
    logic    is_jmp;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, use_imm: 1'b0, mem_re: 1'b0,
             mem_we: 1'b0, is_beq: 1'b0, is_jmp: 1'b0, alu_op: ALU_ADD};
    unique case (opcode)
      OP_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_LDW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_re  = 1'b1;
      end
      OP_STW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_beq = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_JMP:  ctrl.is_jmp = 1'b1;
      default: ;
    endcase
  end

  // R6: a store never also commits a register
  always_comb begin
    assert_store_no_wb_R6: assert (!(ctrl.mem_we && ctrl.reg_we));
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regbank.sv
module sc_regbank #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
  assign rd_c = (ra_c == '0) ? '0 : regs[ra_c];

  // R4: a committed result is held in the target register after the edge
  assert_wr_lands_R4: assert property (@(posedge clk) disable iff (rst)
    (we && (wa != '0)) |=> (regs[$past(wa)] == $past(wd)));

  // R3: a write aimed at register 0 leaves it cleared
  assert_zero_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (we && (wa == '0)) |=> (regs[0] == '0));

endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_imem_en,
  input  logic        ld_dmem_en,
  input  logic [31:0] ld_addr,
  input  logic [31:0] ld_data,
  input  logic [4:0]  peek_sel,
  output logic [31:0] peek_data,
  output logic [31:0] pc_out
);

  localparam int W  = XLEN;
  localparam int IW = $clog2(IMEM_WORDS);
  localparam int DW = $clog2(DMEM_WORDS);

  logic [W-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
  logic [W-1:0] instr, simm, ra_val, rb_val, alu_b, alu_y, dmem_q, wb_val;
  logic         alu_zero, br_taken, core_store;
  logic [4:0]   f_rs, f_rt, f_rd, wb_addr;
  ctrl_t        ctrl;

  sc_wordmem #(.W(W), .DEPTH(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (ld_imem_en),
    .waddr (ld_addr[IW+1:2]),
    .wdata (ld_data),
    .raddr (pc_q[IW+1:2]),
    .rdata (instr)
  );

  assign f_rs = instr[25:21];
  assign f_rt = instr[20:16];
  assign f_rd = instr[15:11];
  assign simm = {{(W-16){instr[15]}}, instr[15:0]};

  sc_decoder u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign wb_addr = ctrl.dst_is_rd ? f_rd : f_rt;
  assign wb_val  = ctrl.mem_re ? dmem_q : alu_y;

  sc_regbank #(.W(W), .NREG(32)) u_regs (
    .clk  (clk),
    .rst  (rst),
    .ra_a (f_rs),
    .ra_b (f_rt),
    .ra_c (peek_sel),
    .rd_a (ra_val),
    .rd_b (rb_val),
    .rd_c (peek_data),
    .we   (ctrl.reg_we),
    .wa   (wb_addr),
    .wd   (wb_val)
  );

  assign alu_b = ctrl.use_imm ? simm : rb_val;

  sc_alu #(.W(W)) u_alu (
    .a    (ra_val),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign core_store = ctrl.mem_we & ~rst;

  sc_wordmem #(.W(W), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (ld_dmem_en | core_store),
    .waddr (ld_dmem_en ? ld_addr[DW+1:2] : alu_y[DW+1:2]),
    .wdata (ld_dmem_en ? ld_data : rb_val),
    .raddr (alu_y[DW+1:2]),
    .rdata (dmem_q)
  );

  assign pc_plus4   = pc_q + W'(4);
  assign br_target  = pc_plus4 + {simm[W-3:0], 2'b00};
  assign jmp_target = {pc_plus4[W-1:28], instr[25:0], 2'b00};
  assign br_taken   = ctrl.is_beq & alu_zero;

  always_comb begin
    if (ctrl.is_jmp)  pc_next = jmp_target;
    else if (br_taken) pc_next = br_target;
    else               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_out = pc_q;

  logic unused_bits;
  assign unused_bits = ^{ld_addr[31:IW+2], ld_addr[1:0], instr[10:6],
                         alu_y[W-1:DW+2], alu_y[1:0]};

  // R2: straight-line flow steps by one word
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.is_jmp && !br_taken) |=> (pc_q == $past(pc_q) + 32'd4));

  // R2: alignment is never lost
  assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    (pc_q[1:0] == 2'b00));

  // R8: a jump lands on the target field scaled to bytes
  assert_jump_lands_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl.is_jmp |=> (pc_q[27:0] == {$past(instr[25:0]), 2'b00}));

  // R7: an unequal compare falls through
  assert_beq_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl.is_beq && (ra_val != rb_val)) |=> (pc_q == $past(pc_q) + 32'd4));

endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_imem_en = 1'b0;
  logic        ld_dmem_en = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  peek_sel = '0;
  logic [31:0] peek_data;
  logic [31:0] pc_out;

  int total = 0;
  int bad = 0;
  bit run_go = 1'b0;
  bit mon_done = 1'b0;
  bit all_done = 1'b0;
  logic [31:0] exp_pc_q [$];

  always #2 clk = ~clk;

  sc_core uut (
    .clk        (clk),
    .rst        (rst),
    .ld_imem_en (ld_imem_en),
    .ld_dmem_en (ld_dmem_en),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .peek_sel   (peek_sel),
    .peek_data  (peek_data),
    .pc_out     (pc_out)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_word(input bit to_imem, input int idx, input logic [31:0] val);
    @(negedge clk);
    ld_imem_en = to_imem;
    ld_dmem_en = !to_imem;
    ld_addr    = idx * 4;
    ld_data    = val;
    @(negedge clk);
    ld_imem_en = 1'b0;
    ld_dmem_en = 1'b0;
  endtask

  task automatic push_pc(input logic [31:0] v);
    exp_pc_q.push_back(v);
  endtask

  task automatic check_reg(input string req, input logic [4:0] r, input logic [31:0] exp);
    peek_sel = r;
    #1;
    check(req, peek_data, exp);
  endtask

  // monitor: pops one expected PC per cycle once the core runs
  initial begin
    wait (run_go);
    while (exp_pc_q.size() > 0) begin
      check("R2/R7/R8 pc trace", pc_out, exp_pc_q.pop_front());
      @(negedge clk);
    end
    mon_done = 1'b1;
  end

  // driver
  initial begin
    logic [31:0] prog [25];
    prog[0]  = enc_i(6'h08, 5'd0, 5'd1, 16'd5);
    prog[1]  = enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD);
    prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
    prog[3]  = enc_r(5'd2, 5'd1, 5'd4, 6'h22);
    prog[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'h24);
    prog[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'h25);
    prog[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'h2A);
    prog[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'h2A);
    prog[8]  = enc_i(6'h08, 5'd0, 5'd0, 16'd7);
    prog[9]  = enc_i(6'h2B, 5'd0, 5'd1, 16'd8);
    prog[10] = enc_i(6'h23, 5'd0, 5'd9, 16'd8);
    prog[11] = enc_i(6'h08, 5'd0, 5'd11, 16'd4);
    prog[12] = enc_r(5'd11, 5'd11, 5'd11, 6'h20);
    prog[13] = enc_i(6'h08, 5'd0, 5'd13, 16'd12);
    prog[14] = enc_i(6'h23, 5'd13, 5'd12, 16'hFFFC);
    prog[15] = enc_i(6'h04, 5'd1, 5'd9, 16'd2);
    prog[16] = enc_i(6'h08, 5'd0, 5'd14, 16'd99);
    prog[17] = enc_i(6'h08, 5'd0, 5'd14, 16'd98);
    prog[18] = enc_i(6'h04, 5'd1, 5'd2, 16'd5);
    prog[19] = enc_i(6'h3F, 5'd0, 5'd18, 16'h0055);
    prog[20] = enc_i(6'h23, 5'd0, 5'd17, 16'd20);
    prog[21] = enc_j(26'd24);
    prog[22] = enc_i(6'h08, 5'd0, 5'd16, 16'd1);
    prog[23] = enc_i(6'h08, 5'd0, 5'd16, 16'd2);
    prog[24] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);

    // R10: preload both stores while reset is held
    for (int i = 0; i < 25; i++) load_word(1'b1, i, prog[i]);
    load_word(1'b0, 5, 32'h1234ABCD);
    load_word(1'b0, 2, 32'hDEAD0000);

    @(negedge clk);
    check("R1 pc in reset", pc_out, 32'h0);
    check_reg("R1 reg in reset", 5'd1, 32'h0);

    for (int i = 0; i <= 15; i++) push_pc(i * 4);
    push_pc(32'd72); push_pc(32'd76); push_pc(32'd80); push_pc(32'd84);
    for (int i = 0; i < 10; i++) push_pc(32'd96);

    @(negedge clk);
    rst = 1'b0;
    run_go = 1'b1;
    wait (mon_done);
    @(negedge clk);

    check_reg("R5 addi positive", 5'd1, 32'd5);
    check_reg("R5 addi negative", 5'd2, 32'hFFFFFFFD);
    check_reg("R4 add", 5'd3, 32'd2);
    check_reg("R4 sub", 5'd4, 32'hFFFFFFF8);
    check_reg("R4 and", 5'd5, 32'd5);
    check_reg("R4 or", 5'd6, 32'hFFFFFFFD);
    check_reg("R4 slt true", 5'd7, 32'd1);
    check_reg("R4 slt false", 5'd8, 32'd0);
    check_reg("R3 zero reg", 5'd0, 32'd0);
    check_reg("R6 store then load", 5'd9, 32'd5);
    check_reg("R4 same reg doubled", 5'd11, 32'd8);
    check_reg("R6 negative offset", 5'd12, 32'd5);
    check_reg("R7 skipped by branch", 5'd14, 32'd0);
    check_reg("R8 skipped by jump", 5'd16, 32'd0);
    check_reg("R10 preloaded data", 5'd17, 32'h1234ABCD);
    check_reg("R9 unknown opcode no write", 5'd18, 32'd0);

    all_done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!all_done) begin
      total++;
      bad++;
      $display("FAIL watchdog run hung actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule